// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block keeps an asynchronous DRAM refreshed from the controller side and moves the part into and out of its low-power self-refresh state. In normal running, a free-running interval timer asks for one CAS-before-RAS (CBR) refresh every refresh interval. A CBR cycle lowers the column strobe first and the row strobe second. It then raises the row strobe first and the column strobe second, and it is followed by a precharge gap with both strobes high.

Software asks for low power by raising `sleep_req`. The sequencer then runs a back-to-back burst of CBR cycles that covers every row once. Straight after the last one, it lowers both strobes and holds them for a margin above the self-refresh activation threshold. It raises `sleep_ack` only once that hold has elapsed. A `wake_req` is honoured only after that point. On wake, the row strobe rises, then the column strobe, and the self-refresh precharge time is respected. A second full burst sweep then starts at once, before distributed refresh resumes.

All time limits are derived from one cycles-per-microsecond parameter. The refresh interval is 15.6 µs and the self-refresh hold is 110 µs.

Top module: `selfref_seq`

## Requirements
- R1: While reset is asserted, `ras_n` and `cas_n` are 1 and `sleep_ack` is 0.
- R2: The row strobe falls only when the column strobe was already low on the previous cycle.
- R3: The column strobe rises only when the row strobe is high on that cycle and was high on the previous one.
- R4: In a CBR refresh, `ras_n` is low for exactly LOW_CYC cycles. Every fall of `cas_n` is preceded by at least PRE_CYC cycles with both strobes high.
- R5: With no sleep activity, successive CBR refreshes are exactly floor(CYC_PER_US*15.6) cycles apart.
- R6: A `sleep_req` seen while idle produces exactly ROWS back-to-back CBR refreshes. The self-refresh row-strobe fall follows the last refresh's row-strobe rise by PRE_CYC+2 cycles, which is within one refresh interval.
- R7: In self refresh, `ras_n` stays low for more than HOLD = CYC_PER_US*110 cycles. A `wake_req` during the hold does not shorten it; the strobe is then low for exactly HOLD+1 cycles.
- R8: `sleep_ack` rises exactly HOLD cycles after the self-refresh row-strobe fall. It stays 1 with both strobes low until a wake is taken, and it is never 1 outside that state.
- R9: On wake, the row strobe rises first. After SRPRE_CYC precharge cycles a burst of ROWS CBR refreshes begins. The last of them raises `ras_n` at SRPRE_CYC+3+LOW_CYC+(ROWS-1)*(LOW_CYC+PRE_CYC+3) cycles after the self-refresh row-strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | Host request to enter self refresh |
| wake_req | input | 1 | Host request to leave self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| sleep_ack | output | 1 | High while self refresh is engaged |

## Verification
The bench runs a small configuration of eight rows at four cycles per microsecond. It predicts every strobe edge arithmetically.

- **Entry sweep.** The bench counts the refreshes in the entry sweep and times the gap to the self-refresh fall. A design that skipped or repeated a row, or paused before entry, shows up as a wrong count or a wrong gap.
- **Early wake.** It raises `wake_req` inside the forbidden 10 µs to 100 µs window. A sequencer that released the row strobe there would show a short low run and would be caught.
- **Exit burst.** It times the burst after wake to the exact cycle. A design that waited for the interval timer, or skipped the exit precharge, would land off that cycle.
- **Strobe order.** Order and width checks on every strobe edge catch swapped release order and short precharge.

// File: rtl/selfref_pkg.sv
package selfref_pkg;

  typedef enum logic [3:0] {
    ST_PRE,       // both strobes high, refresh precharge
    ST_IDLE,      // both strobes high, waiting for work
    ST_CAS,       // column strobe low ahead of row strobe
    ST_BOTH,      // both low, CBR refresh in progress
    ST_RREL,      // row strobe released first
    ST_SR_CAS,    // column strobe low ahead of self-refresh row fall
    ST_SR_HOLD,   // both low, counting activation hold
    ST_SR_SLEEP,  // self refresh engaged, host acknowledged
    ST_SR_RREL,   // exit: row strobe released first
    ST_SR_PRE     // exit precharge
  } sr_state_e;

endpackage

// File: rtl/selfref_rstsync.sv
module selfref_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/selfref_tick.sv
module selfref_tick #(
  parameter int PERIOD = 3900
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int W = $clog2(PERIOD);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == W'(PERIOD - 1));

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/selfref_sweep.sv
module selfref_sweep #(
  parameter int ROWS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic zero
);

  localparam int W = $clog2(ROWS + 1);

  logic [W-1:0] left_q, left_d;
  logic         left_en;

  assign zero    = (left_q == '0);
  assign left_en = load | (dec & ~zero);

  always_comb begin
    if (load) left_d = W'(ROWS);
    else      left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

endmodule

// File: rtl/selfref_seq.sv
module selfref_seq #(
  parameter int CYC_PER_US = 250,
  parameter int ROWS       = 4096,
  parameter int LOW_CYC    = 4,
  parameter int PRE_CYC    = 3,
  parameter int SRPRE_CYC  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  output logic ras_n,
  output logic cas_n,
  output logic sleep_ack
);

  import selfref_pkg::*;

  localparam int TICK_CYC = (CYC_PER_US * 156) / 10;
  localparam int HOLD_CYC = CYC_PER_US * 110;
  localparam int CNT_W    = $clog2(HOLD_CYC + SRPRE_CYC + 1);

  logic             rst_i_n;
  logic             tick;
  logic             sweep_zero;
  logic             sweep_load;
  logic             sweep_dec;
  logic             clr_pend;
  sr_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             enter_q, enter_d;
  logic             pend_q, pend_d;

  selfref_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  selfref_tick #(.PERIOD(TICK_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_i_n),
    .tick  (tick)
  );

  selfref_sweep #(.ROWS(ROWS)) u_sweep (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (sweep_load),
    .dec   (sweep_dec),
    .zero  (sweep_zero)
  );

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q + 1'b1;
    enter_d    = enter_q;
    sweep_load = 1'b0;
    sweep_dec  = 1'b0;
    unique case (st_q)
      ST_PRE: begin
        if (cnt_q == CNT_W'(PRE_CYC - 1)) begin
          cnt_d = '0;
          st_d  = (enter_q && sweep_zero) ? ST_SR_CAS : ST_IDLE;
        end
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (sleep_req && sweep_zero && !enter_q) begin
          sweep_load = 1'b1;
          enter_d    = 1'b1;
          st_d       = ST_CAS;
        end else if (!sweep_zero || pend_q) begin
          st_d = ST_CAS;
        end
      end
      ST_CAS: begin
        cnt_d = '0;
        st_d  = ST_BOTH;
      end
      ST_BOTH: begin
        if (cnt_q == CNT_W'(LOW_CYC - 1)) begin
          cnt_d = '0;
          st_d  = ST_RREL;
        end
      end
      ST_RREL: begin
        cnt_d     = '0;
        sweep_dec = 1'b1;
        st_d      = ST_PRE;
      end
      ST_SR_CAS: begin
        cnt_d = '0;
        st_d  = ST_SR_HOLD;
      end
      ST_SR_HOLD: begin
        if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
          cnt_d = '0;
          st_d  = ST_SR_SLEEP;
        end
      end
      ST_SR_SLEEP: begin
        cnt_d = '0;
        if (wake_req) st_d = ST_SR_RREL;
      end
      ST_SR_RREL: begin
        cnt_d   = '0;
        enter_d = 1'b0;
        st_d    = ST_SR_PRE;
      end
      ST_SR_PRE: begin
        if (cnt_q == CNT_W'(SRPRE_CYC - 1)) begin
          cnt_d      = '0;
          sweep_load = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      default: begin
        cnt_d = '0;
        st_d  = ST_PRE;
      end
    endcase
  end

  // a refresh request is consumed when a CBR starts or a new sweep is loaded
  assign clr_pend = sweep_load | ((st_q == ST_IDLE) && (st_d == ST_CAS));
  assign pend_d   = tick | (pend_q & ~clr_pend);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_PRE;
      cnt_q   <= '0;
      enter_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      enter_q <= enter_d;
      pend_q  <= pend_d;
    end
  end

  assign ras_n = !(st_q inside {ST_BOTH, ST_SR_HOLD, ST_SR_SLEEP});
  assign cas_n = !(st_q inside {ST_CAS, ST_BOTH, ST_RREL, ST_SR_CAS,
                                ST_SR_HOLD, ST_SR_SLEEP, ST_SR_RREL});
  assign sleep_ack = (st_q == ST_SR_SLEEP);

endmodule

// File: rtl/selfref_seq_chk.sv
module selfref_seq_chk #(
  parameter int CYC_PER_US = 250,
  parameter int LOW_CYC    = 4,
  parameter int PRE_CYC    = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic sleep_ack
);

  localparam int HOLD_CYC = CYC_PER_US * 110;

  logic [31:0] ras_run;
  logic [31:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_run <= '0;
      hi_run  <= '0;
    end else begin
      ras_run <= ras_n ? 32'd0 : ras_run + 32'd1;
      hi_run  <= (ras_n && cas_n) ? hi_run + 32'd1 : 32'd0;
    end
  end

  // R2
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !$past(cas_n));

  // R3
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (ras_n && $past(ras_n)));

  // R4
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (hi_run >= 32'(PRE_CYC)));

  // R7
  ras_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_run == 32'(LOW_CYC) || ras_run > 32'(HOLD_CYC)));

  // R8
  ack_engaged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> (!ras_n && !cas_n && ras_run >= 32'(HOLD_CYC)));

endmodule

bind selfref_seq selfref_seq_chk #(
  .CYC_PER_US (CYC_PER_US),
  .LOW_CYC    (LOW_CYC),
  .PRE_CYC    (PRE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .sleep_ack (sleep_ack)
);

// File: tb/selfref_seq_test.sv
`timescale 1ns/100ps
module selfref_seq_test;

  localparam int CPU   = 4;
  localparam int ROWS  = 8;
  localparam int LOW   = 3;
  localparam int PRE   = 2;
  localparam int SRPRE = 5;
  localparam int TICK  = (CPU * 156) / 10;
  localparam int HOLD  = CPU * 110;
  localparam int PER   = LOW + PRE + 3;
  localparam int SHORT = CPU * 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic wake_req = 1'b0;
  logic ras_n, cas_n, sleep_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  selfref_seq #(
    .CYC_PER_US (CPU),
    .ROWS       (ROWS),
    .LOW_CYC    (LOW),
    .PRE_CYC    (PRE),
    .SRPRE_CYC  (SRPRE)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .wake_req  (wake_req),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .sleep_ack (sleep_ack)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor state, sampled at the falling edge
  longint cyc = 0;
  int     run = 0;
  int     hi  = 0;
  int     cbr_cnt = 0;
  int     sr_cnt = 0;
  int     ack_cyc_cnt = 0;
  longint last_cbr = 0;
  longint ras_fall = 0;
  longint sr_rise = 0;
  int     sr_run = 0;
  bit     dist_mode = 1'b0;
  bit     have_prev = 1'b0;
  logic   p_ras = 1'b1;
  logic   p_cas = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        chk(!p_cas, "R2 cas low before ras fall", p_cas, 0);
        ras_fall = cyc;
      end
      if (!p_cas && cas_n)
        chk(ras_n && p_ras, "R3 ras high before cas rise", {p_ras, ras_n}, 3);
      if (p_cas && !cas_n)
        chk(hi >= PRE, "R4 precharge before cas fall", hi, PRE);
      if (!p_ras && ras_n) begin
        if (run < SHORT) begin
          chk(run == LOW, "R4 cbr ras low width", run, LOW);
          if (dist_mode && have_prev)
            chk(cyc - last_cbr == TICK, "R5 distributed spacing", cyc - last_cbr, TICK);
          have_prev = 1'b1;
          last_cbr = cyc;
          cbr_cnt++;
        end else begin
          sr_run = run;
          sr_rise = cyc;
          sr_cnt++;
        end
      end
      run = ras_n ? 0 : run + 1;
      hi  = (ras_n && cas_n) ? hi + 1 : 0;
      if (sleep_ack) ack_cyc_cnt++;
    end
    p_ras = ras_n;
    p_cas = cas_n;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    int acks0;
    longint entry_fall;
    longint ack_at;
    longint sr_out;

    // R1: reset state
    repeat (4) step();
    chk(ras_n == 1'b1, "R1 ras_n in reset", ras_n, 1);
    chk(cas_n == 1'b1, "R1 cas_n in reset", cas_n, 1);
    chk(sleep_ack == 1'b0, "R1 sleep_ack in reset", sleep_ack, 0);
    rst_n = 1'b1;
    step();
    chk(ras_n && cas_n && !sleep_ack, "R1 idle after reset", {ras_n, cas_n, sleep_ack}, 6);

    // R5: distributed refresh only
    dist_mode = 1'b1;
    repeat (8 * TICK) step();
    chk(cbr_cnt >= 7, "R5 distributed refresh count", cbr_cnt, 7);
    dist_mode = 1'b0;

    // R6: entry sweep, requested right after a refresh completes
    base = cbr_cnt;
    while (cbr_cnt == base) step();
    base = cbr_cnt;
    sleep_req = 1'b1;
    while (!sleep_ack) step();
    ack_at = cyc;
    entry_fall = ras_fall;
    chk(cbr_cnt - base == ROWS, "R6 refreshes in entry sweep", cbr_cnt - base, ROWS);
    chk(entry_fall - last_cbr == PRE + 2, "R6 entry gap", entry_fall - last_cbr, PRE + 2);
    chk(entry_fall - last_cbr <= TICK, "R6 entry deadline", entry_fall - last_cbr, TICK);
    // R8: acknowledge timing
    chk(ack_at - entry_fall == HOLD, "R8 ack after hold", ack_at - entry_fall, HOLD);
    sleep_req = 1'b0;
    for (int i = 0; i < 50; i++) begin
      step();
      if (!(sleep_ack && !ras_n && !cas_n))
        chk(1'b0, "R8 ack held in self refresh", {sleep_ack, ras_n, cas_n}, 4);
    end
    chk(sleep_ack && !ras_n && !cas_n, "R8 still engaged", {sleep_ack, ras_n, cas_n}, 4);

    // R9: wake and exit burst
    base = sr_cnt;
    wake_req = 1'b1;
    while (sr_cnt == base) step();
    wake_req = 1'b0;
    sr_out = sr_rise;
    chk(sleep_ack == 1'b0, "R8 ack drops on exit", sleep_ack, 0);
    chk(sr_run > HOLD, "R7 self refresh ras low", sr_run, HOLD + 1);
    base = cbr_cnt;
    while (cbr_cnt < base + ROWS) step();
    chk(last_cbr - sr_out == SRPRE + 3 + LOW + (ROWS - 1) * PER,
        "R9 exit burst end", last_cbr - sr_out, SRPRE + 3 + LOW + (ROWS - 1) * PER);

    // R7: wake raised inside the forbidden window is held off
    base = cbr_cnt;
    while (cbr_cnt == base) step();
    sleep_req = 1'b1;
    base = sr_cnt;
    acks0 = ack_cyc_cnt;
    while (!(run >= 50 && run < SHORT * 10 && !cas_n && ras_fall > last_cbr + 1)) step();
    wake_req = 1'b1;
    sleep_req = 1'b0;
    chk(!ras_n, "R7 ras low during hold", ras_n, 0);
    while (sr_cnt == base) step();
    wake_req = 1'b0;
    chk(sr_run == HOLD + 1, "R7 early wake hold length", sr_run, HOLD + 1);
    chk(ack_cyc_cnt - acks0 == 1, "R8 ack for one cycle", ack_cyc_cnt - acks0, 1);
    base = cbr_cnt;
    while (cbr_cnt < base + ROWS) step();
    chk(last_cbr - sr_rise == SRPRE + 3 + LOW + (ROWS - 1) * PER,
        "R9 second exit burst", last_cbr - sr_rise, SRPRE + 3 + LOW + (ROWS - 1) * PER);
    repeat (20) step();

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule